// File: doc/BRIEF.md
# Programmable Signal Crosspoint with Configurable Pin Cells

This block is a routing fabric for a bank of bidirectional pins. Each pin has a cell with an input side and an output side. The output side of each pin can take its value from any pin in the bank. Up to four candidate sources are stored per output, and two other pins pick among them while the block runs. An output can also be tied to a fixed 1 or 0, which stands in for a jumper or a DIP switch. Both sides of a cell can pass the value straight through, hold it in a level-sensitive latch, or capture it on a rising edge. The clock for the latch or register is a dedicated clock input or any chosen pin.

Each pin has one configuration word, written through a synchronous port that takes an address, data and a write strobe, and read back combinationally. Each pin's tri-state enable comes from a chosen pin, with a polarity bit, or is held on. No pin drives until the system has raised the configured flag. Pins appear as three vectors: the sampled input, the output value and the output enable.

Top module: `xpt_crosspoint`

## Requirements
- R1: A word on `cfg_wdata` is stored into the entry at `cfg_addr` on the rising `clk` edge when `cfg_we` is high. `cfg_rdata` returns the entry at `cfg_addr` combinationally and equals the last value written. Reset clears every entry to zero.
- R2: `cfg_done` is sampled on each rising `clk` edge. While the sampled flag is low, and during reset, all of `pin_oe` is 0. This covers the first cycle after `cfg_done` rises and the first cycle after it falls.
- R3: Word layout, LSB first: sources 0..3 in bits [3:0], [7:4], [11:8], [15:12]; select-low pin index in [19:16]; select-high pin index in [23:20]. Path number {pin_in[select-high], pin_in[select-low]} picks the source. The routed value is the input-cell value of that source pin, and any pin may be a source.
- R4: When bit 33 is 1, the output data is bit 34, whatever the routed source carries.
- R5: Output mode in bits [25:24]: 0 and 3 pass the data through, 1 is a latch that is transparent while the cell clock is high and holds while it is low, 2 is a register that samples on the rising cell clock.
- R6: Input mode in bits [27:26] uses the same encoding. It applies to the pin's own `pin_in` bit, clocked by that pin's cell clock, before that pin is used as a source.
- R7: The cell clock is `ded_clk[bits 29+]` when bit 28 is 0. The dedicated index is the low bits of field [32:29], and an index out of range selects `ded_clk[0]`. When bit 28 is 1, the cell clock is `pin_in[bits 32:29]`.
- R8: Output enable is 1 when bit 35 is 1. Otherwise it is 1 when `pin_in[bits 39:36]` equals bit 40, so bit 40 = 1 makes the enable active high and bit 40 = 0 makes it active low.
- R9: `pin_out` of a pin is 0 whenever its `pin_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for configuration and the configured flag |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Pin whose word is written or read |
| cfg_wdata | input | 41 | Configuration word to write |
| cfg_rdata | output | 41 | Configuration word at `cfg_addr` |
| cfg_done | input | 1 | Configuration complete flag |
| ded_clk | input | NUM_DCLK | Dedicated cell clocks |
| pin_in | input | 16 | Values seen at the pins |
| pin_out | output | 16 | Values driven onto the pins |
| pin_oe | output | 16 | Per-pin output enable |

## Verification
A wrong configuration entry shows up on the pins as soon as the logic settles. The wrong source, constant or enable appears on `pin_out` or `pin_oe`, and `cfg_rdata` shows the bad word within one `clk` edge of the write. A latch or register cell holding the wrong value only becomes visible at the next cell-clock event. For that reason, each storage mode is checked both right after a clock edge and while the clock holds still. A configured flag held in the wrong state shows as enabled or disabled pins one system cycle after `cfg_done` changes.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    localparam int XP_PINS  = 16;
    localparam int XP_IDX_W = $clog2(XP_PINS);
    localparam int XP_SRC   = 4;

    typedef enum logic [1:0] {
        CM_COMB  = 2'd0,
        CM_LATCH = 2'd1,
        CM_REG   = 2'd2,
        CM_PASS  = 2'd3
    } cell_mode_e;

    typedef struct packed {
        logic                               oe_hi;
        logic [XP_IDX_W-1:0]                oe_pin;
        logic                               oe_always;
        logic                               k_val;
        logic                               k_en;
        logic [XP_IDX_W-1:0]                clk_idx;
        logic                               clk_pin;
        cell_mode_e                         in_mode;
        cell_mode_e                         out_mode;
        logic [XP_IDX_W-1:0]                sel_b;
        logic [XP_IDX_W-1:0]                sel_a;
        logic [XP_SRC-1:0][XP_IDX_W-1:0]    src;
    } xp_cfg_t;

    localparam int XP_CFG_W = $bits(xp_cfg_t);

    function automatic logic [1:0] path_of(xp_cfg_t c, logic [XP_PINS-1:0] pins);
        return {pins[c.sel_b], pins[c.sel_a]};
    endfunction

    function automatic logic enable_of(xp_cfg_t c, logic [XP_PINS-1:0] pins);
        return c.oe_always | (pins[c.oe_pin] == c.oe_hi);
    endfunction

endpackage

// File: rtl/xpt_cfg_bank.sv
module xpt_cfg_bank
    import xpt_pkg::*;
#(
    parameter int DEPTH = XP_PINS,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  xp_cfg_t           wdata,
    output xp_cfg_t           rdata,
    output xp_cfg_t           words [DEPTH]
);

    xp_cfg_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

    for (genvar k = 0; k < DEPTH; k++) begin : g_out
        assign words[k] = mem_q[k];
    end

endmodule

// File: rtl/xpt_mode_cell.sv
module xpt_mode_cell
    import xpt_pkg::*;
(
    input  logic       d,
    input  logic       cclk,
    input  cell_mode_e mode,
    output logic       q
);

    logic lat_q;
    logic reg_q;

    // transparent while the cell clock is high
    always_latch begin
        if (cclk) lat_q = d;
    end

    always_ff @(posedge cclk) begin
        reg_q <= d;
    end

    always_comb begin
        unique case (mode)
            CM_LATCH: q = lat_q;
            CM_REG:   q = reg_q;
            default:  q = d;
        endcase
    end

endmodule

// File: rtl/xpt_out_lane.sv
module xpt_out_lane
    import xpt_pkg::*;
#(
    parameter int NP = XP_PINS
) (
    input  xp_cfg_t         cfg,
    input  logic [NP-1:0]   in_val,
    input  logic [NP-1:0]   pin_in,
    input  logic            cclk,
    input  logic            cfg_ok,
    output logic            out_bit,
    output logic            oe_bit
);

    logic [1:0] path;
    logic       routed;
    logic       data;
    logic       held;

    assign path   = path_of(cfg, pin_in);
    assign routed = in_val[cfg.src[path]];
    assign data   = cfg.k_en ? cfg.k_val : routed;

    xpt_mode_cell u_ocell (
        .d    (data),
        .cclk (cclk),
        .mode (cfg.out_mode),
        .q    (held)
    );

    assign oe_bit  = cfg_ok & enable_of(cfg, pin_in);
    assign out_bit = oe_bit & held;

endmodule

// File: rtl/xpt_crosspoint.sv
module xpt_crosspoint
    import xpt_pkg::*;
#(
    parameter int NUM_DCLK = 2,
    localparam int NP      = XP_PINS,
    localparam int DCW     = (NUM_DCLK > 1) ? $clog2(NUM_DCLK) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [XP_IDX_W-1:0]     cfg_addr,
    input  logic [XP_CFG_W-1:0]     cfg_wdata,
    output logic [XP_CFG_W-1:0]     cfg_rdata,
    input  logic                    cfg_done,
    input  logic [NUM_DCLK-1:0]     ded_clk,
    input  logic [NP-1:0]           pin_in,
    output logic [NP-1:0]           pin_out,
    output logic [NP-1:0]           pin_oe
);

    xp_cfg_t       cfg_q [NP];
    xp_cfg_t       rd_word;
    logic          cfg_ok;
    logic [NP-1:0] cclk;
    logic [NP-1:0] in_val;

    xpt_cfg_bank #(.DEPTH(NP)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (xp_cfg_t'(cfg_wdata)),
        .rdata (rd_word),
        .words (cfg_q)
    );

    assign cfg_rdata = rd_word;

    always_ff @(posedge clk) begin
        if (rst) cfg_ok <= 1'b0;
        else     cfg_ok <= cfg_done;
    end

    for (genvar i = 0; i < NP; i++) begin : g_pin
        logic [DCW-1:0] didx;
        logic           dclk;

        assign didx = cfg_q[i].clk_idx[DCW-1:0];
        assign dclk = (int'(didx) < NUM_DCLK) ? ded_clk[didx] : ded_clk[0];
        assign cclk[i] = cfg_q[i].clk_pin ? pin_in[cfg_q[i].clk_idx] : dclk;

        xpt_mode_cell u_icell (
            .d    (pin_in[i]),
            .cclk (cclk[i]),
            .mode (cfg_q[i].in_mode),
            .q    (in_val[i])
        );

        xpt_out_lane #(.NP(NP)) u_lane (
            .cfg     (cfg_q[i]),
            .in_val  (in_val),
            .pin_in  (pin_in),
            .cclk    (cclk[i]),
            .cfg_ok  (cfg_ok),
            .out_bit (pin_out[i]),
            .oe_bit  (pin_oe[i])
        );
    end

endmodule

// File: rtl/xpt_crosspoint_chk.sv
module xpt_crosspoint_chk
    import xpt_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_we,
    input logic [XP_IDX_W-1:0]  cfg_addr,
    input logic [XP_CFG_W-1:0]  cfg_wdata,
    input logic [XP_CFG_W-1:0]  cfg_rdata,
    input logic                 cfg_done,
    input xp_cfg_t              cfg_q [XP_PINS],
    input logic [XP_PINS-1:0]   pin_out,
    input logic [XP_PINS-1:0]   pin_oe
);

    // R1: a written word is visible at the read port one edge later
    a_r1_write_visible: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_we) && !$past(rst) && cfg_addr == $past(cfg_addr))
        |-> cfg_rdata == $past(cfg_wdata));

    // R2: no pin drives while the sampled flag is low
    a_r2_hiz_until_done: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_done) |-> pin_oe == '0);

    for (genvar i = 0; i < XP_PINS; i++) begin : g_chk
        // R4: constant drive in pass-through output mode
        a_r4_const_drive: assert property (@(posedge clk) disable iff (rst)
            (cfg_q[i].k_en && (cfg_q[i].out_mode == CM_COMB || cfg_q[i].out_mode == CM_PASS)
             && pin_oe[i]) |-> pin_out[i] == cfg_q[i].k_val);

        // R8: always-enable drives once configured
        a_r8_oe_always: assert property (@(posedge clk) disable iff (rst)
            ($past(cfg_done) && cfg_q[i].oe_always) |-> pin_oe[i]);

        // R9: a disabled pin carries 0
        a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
            !pin_oe[i] |-> !pin_out[i]);
    end

endmodule

bind xpt_crosspoint xpt_crosspoint_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_done  (cfg_done),
    .cfg_q     (cfg_q),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/xpt_crosspoint_tb_top.sv
module xpt_crosspoint_tb_top;
    import xpt_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cfg_we = 1'b0;
    logic [XP_IDX_W-1:0] cfg_addr = '0;
    logic [XP_CFG_W-1:0] cfg_wdata = '0;
    logic [XP_CFG_W-1:0] cfg_rdata;
    logic                cfg_done = 1'b0;
    logic [1:0]          ded_clk = 2'b00;
    logic [15:0]         pin_in = '0;
    logic [15:0]         pin_out;
    logic [15:0]         pin_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    xp_cfg_t sh [16];

    always #10 clk = ~clk;

    xpt_crosspoint #(.NUM_DCLK(2)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_done(cfg_done),
        .ded_clk(ded_clk), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // pins whose output sits on a storage mode are left out of the table compare
    localparam logic [15:0] TBL_MASK = 16'hFF1F;
    localparam logic [15:0] STIM [8] = '{
        16'h0000, 16'hFFFF, 16'h0008, 16'h4020,
        16'h8080, 16'hC200, 16'h3001, 16'h1000
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_cfg(input int a, input xp_cfg_t w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a[XP_IDX_W-1:0]; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        sh[a] = w;
    endtask

    function automatic logic [31:0] model(logic [15:0] p);
        logic [15:0] o, e;
        for (int i = 0; i < 16; i++) begin
            xp_cfg_t c = sh[i];
            logic [1:0] s = {p[c.sel_b], p[c.sel_a]};
            logic d = c.k_en ? c.k_val : p[c.src[s]];
            e[i] = c.oe_always | (p[c.oe_pin] == c.oe_hi);
            o[i] = e[i] & d;
        end
        return {e, o};
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        xp_cfg_t c;
        logic [31:0] m;
        for (int i = 0; i < 16; i++) sh[i] = '0;

        repeat (3) @(negedge clk);
        cfg_addr = 4'd0;
        #1;
        chk("R1 reset clears word", cfg_rdata, '0);
        chk("R2 no enable in reset", pin_oe, 16'h0000);
        rst = 1'b0;

        // pin 0: four sources, path from pins 15 (high) and 14 (low)
        c = '0; c.src[0] = 4'd3; c.src[1] = 4'd5; c.src[2] = 4'd7; c.src[3] = 4'd9;
        c.sel_a = 4'd14; c.sel_b = 4'd15; c.oe_always = 1'b1;
        put_cfg(0, c);
        c = '0; c.k_en = 1'b1; c.k_val = 1'b1; c.oe_always = 1'b1; put_cfg(1, c);
        c = '0; c.k_en = 1'b1; c.k_val = 1'b0; c.src = {4{4'd15}}; c.oe_always = 1'b1; put_cfg(2, c);
        c = '0; c.src = {4{4'd12}}; c.oe_pin = 4'd13; c.oe_hi = 1'b1; put_cfg(3, c);
        c = '0; c.src = {4{4'd12}}; c.oe_pin = 4'd13; c.oe_hi = 1'b0; put_cfg(4, c);
        // storage-mode pins
        c = '0; c.src = {4{4'd10}}; c.out_mode = CM_LATCH; c.clk_pin = 1'b0; c.clk_idx = 4'd0;
        c.oe_always = 1'b1; put_cfg(5, c);
        c = '0; c.src = {4{4'd10}}; c.out_mode = CM_REG; c.clk_pin = 1'b1; c.clk_idx = 4'd11;
        c.oe_always = 1'b1; put_cfg(6, c);
        c = '0; c.src = {4{4'd8}}; c.oe_always = 1'b1; put_cfg(7, c);
        c = '0; c.in_mode = CM_REG; c.clk_pin = 1'b0; c.clk_idx = 4'd1; put_cfg(8, c);

        cfg_addr = 4'd0; #1;
        chk("R1 readback pin0 word", cfg_rdata, sh[0]);
        cfg_addr = 4'd6; #1;
        chk("R1 readback pin6 word", cfg_rdata, sh[6]);

        pin_in = 16'hFFFF; #2;
        chk("R2 unconfigured oe", pin_oe, 16'h0000);
        chk("R2 unconfigured out", pin_out, 16'h0000);

        @(negedge clk); cfg_done = 1'b1;
        @(negedge clk); #1;

        // table walk: routing, constants, enables and polarity
        for (int t = 0; t < 8; t++) begin
            pin_in = STIM[t]; #2;
            m = model(STIM[t]);
            chk($sformatf("R3 R4 R9 table %0d out", t), pin_out & TBL_MASK, m[15:0] & TBL_MASK);
            chk($sformatf("R8 table %0d oe", t), pin_oe, m[31:16]);
        end

        // R4: constants hold against any source value
        pin_in = 16'h8000; #2; chk("R4 const low ignores src", pin_out[2], 1'b0);
        pin_in = 16'h0000; #2; chk("R4 const high", pin_out[1], 1'b1);
        // R8: polarity pair on pins 3/4
        pin_in = 16'h3000; #2; chk("R8 active-high on, low off", {pin_oe[4], pin_oe[3]}, 2'b01);
        pin_in = 16'h1000; #2; chk("R8 active-low on, high off", {pin_oe[4], pin_oe[3]}, 2'b10);

        // R5 R7: latch on dedicated clock 0
        pin_in = 16'h0400; ded_clk = 2'b01; #2; chk("R5 latch transparent", pin_out[5], 1'b1);
        pin_in = 16'h0000; #2;                   chk("R5 latch follows", pin_out[5], 1'b0);
        ded_clk = 2'b00; #2; pin_in = 16'h0400; #2; chk("R5 latch holds", pin_out[5], 1'b0);
        ded_clk = 2'b01; #2;                     chk("R5 latch reopens", pin_out[5], 1'b1);
        ded_clk = 2'b00; #2;

        // R5 R7: register clocked from pin 11
        pin_in = 16'h0400; #2;
        pin_in = 16'h0C00; #2; chk("R7 pin clock edge captures", pin_out[6], 1'b1);
        pin_in = 16'h0800; #2; chk("R5 reg holds while clock high", pin_out[6], 1'b1);
        pin_in = 16'h0000; #2; chk("R5 reg holds on falling clock", pin_out[6], 1'b1);
        pin_in = 16'h0800; #2; chk("R5 reg captures 0", pin_out[6], 1'b0);

        // R6: registered input cell of pin 8, clock ded_clk[1], seen via pin 7
        pin_in = 16'h0100; #2; ded_clk = 2'b10; #2; chk("R6 input reg captures", pin_out[7], 1'b1);
        pin_in = 16'h0000; #2; chk("R6 input reg holds", pin_out[7], 1'b1);
        ded_clk = 2'b00; #2; ded_clk = 2'b10; #2; chk("R6 input reg recaptures", pin_out[7], 1'b0);
        ded_clk = 2'b00;

        // R1: live rewrite of pin 3 takes effect after the write edge
        c = '0; c.k_en = 1'b1; c.k_val = 1'b1; c.oe_always = 1'b1;
        put_cfg(3, c);
        cfg_addr = 4'd3; #1;
        chk("R1 rewrite readback", cfg_rdata, sh[3]);
        chk("R1 rewrite drives", {pin_oe[3], pin_out[3]}, 2'b11);

        // R2: dropping the flag disables after one edge
        @(negedge clk); cfg_done = 1'b0;
        #1; chk("R2 still on before edge", pin_oe[1], 1'b1);
        @(negedge clk); #1;
        chk("R2 off after flag low", pin_oe, 16'h0000);

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; cfg_addr = 4'd0; #1;
        chk("R1 reset wipes word", cfg_rdata, '0);

        finish_run();
    end

endmodule